// File: doc/BRIEF.md
# Timer channel enable and polarity control

This block sits beside the counter of a four-channel capture/compare timer. It owns the 16-bit enable/polarity register and decides, for each channel, whether a compare result reaches the pins and with which polarity. In input mode it picks which edges of the filtered input produce a capture strobe, and it suppresses that strobe unless capture is enabled.

The register is written through a simple write-enable port and is always readable. A lock level from the protection logic can freeze the polarity fields. On channels that have a complementary output, polarity can be double-buffered so that a new setting reaches the pins only on a commutation pulse. Channel mode, idle levels and the compare reference come from neighbouring logic.

Top module: `tim_chan_ctl`

## Requirements
- R1: Channel n (1..4) owns enable at bit 4(n-1), polarity at bit 4(n-1)+1 and complementary polarity at bit 4(n-1)+3. Every other bit reads 0, and reset clears the whole register.
- R2: Enable bits take the written value on every write, whatever the lock level.
- R3: In output mode (mode field 00), an enabled channel drives `ocOut` = `ocRef` XOR polarity, so polarity 1 means active low. A disabled channel drives its `idleLevel` bit.
- R4: With the default parameters, channels 1 to 3 have a complementary output. When enabled, it drives NOT `ocRef` XOR complementary polarity, and when disabled it drives `idleLevelN`. Channel 4 has no complementary output and always drives `idleLevelN`.
- R5: In input mode (mode field not 00), the code {complementary polarity, polarity} selects the capture edge: 00 rising, 01 falling, 11 both. Each edge gives a strobe of exactly one clock, present in the cycle when `tiIn` differs from its sample at the previous edge.
- R6: The reserved code 10 detects rising edges only.
- R7: `capStrobe` stays 0 for a channel that is disabled or in output mode.
- R8: `tiPol` equals `tiIn` inverted for code 01 and equals `tiIn` for every other code.
- R9: While `lockLevel` is 2 or 3, writes leave the polarity bits unchanged.
- R10: While `lockLevel` is 2 or 3, writes leave the complementary polarity bit unchanged for channels in output mode. In input mode that bit is written normally.
- R11: With `preloadEn` = 1, on channels 1 to 3 a written polarity reads back at once, but it reaches the outputs only after the clock edge that samples `comEvent` = 1.
- R12: Channel 4 uses a newly written polarity at once, even with `preloadEn` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Register read data |
| lockLevel | input | 2 | Protection level from the break unit |
| preloadEn | input | 1 | Enable polarity preload on complementary channels |
| comEvent | input | 1 | Single-cycle commutation pulse |
| chMode | input | 8 | Two bits per channel; 00 output, otherwise input |
| ocRef | input | 4 | Compare reference per channel, active high |
| idleLevel | input | 4 | Main output level while disabled |
| idleLevelN | input | 4 | Complementary output level while disabled |
| ocOut | output | 4 | Main channel outputs |
| ocOutN | output | 4 | Complementary channel outputs |
| tiIn | input | 4 | Filtered timer inputs |
| tiPol | output | 4 | Inputs after polarity selection |
| capStrobe | output | 4 | Gated one-clock capture strobes |

## Verification
If a stored enable or polarity bit is wrong, `rdData` shows it immediately after the write edge. In output mode, `ocOut` or `ocOutN` shows the same error combinationally in that cycle. If the held polarity copy is wrong, the register still reads correctly while the pins disagree after the commutation edge, so the bench compares the pins before and after a commutation pulse. A wrong edge history appears as a missing, extra or doubled `capStrobe` in the cycle after `tiIn` moves, so the bench checks both the edge cycle and the cycle after it.

// File: rtl/tim_chan_pkg.sv
package tim_chan_pkg;
  localparam int CH_COUNT = 4;
  localparam int FIELD_W  = 4;
  // bit offsets inside each channel nibble
  localparam int EN_OFS   = 0;
  localparam int POL_OFS  = 1;
  localparam int NPOL_OFS = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic [CH_COUNT-1:0] ldEn;
    logic [CH_COUNT-1:0] ldPol;
    logic [CH_COUNT-1:0] ldNPol;
    logic [CH_COUNT-1:0] holdPol;
    logic [CH_COUNT-1:0] xferPol;
  } ctlStrobe_t;
endpackage

// File: rtl/tim_chan_ctrl.sv
module tim_chan_ctrl import tim_chan_pkg::*; #(
  parameter int NUM_CH = CH_COUNT,
  parameter logic [CH_COUNT-1:0] HAS_COMP = 4'b0111
) (
  input  logic              wrEn,
  input  logic [1:0]        lockLevel,
  input  logic [2*NUM_CH-1:0] chMode,
  input  logic              preloadEn,
  input  logic              comEvent,
  output ctlStrobe_t        strobes
);
  logic polLocked;
  assign polLocked = lockLevel[1];   // levels 2 and 3

  always_comb begin
    strobes = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      strobes.ldEn[i]    = wrEn;
      strobes.ldPol[i]   = wrEn && !polLocked;
      strobes.ldNPol[i]  = wrEn && !(polLocked && (chMode[2*i +: 2] == 2'b00));
      strobes.holdPol[i] = preloadEn && HAS_COMP[i];
      strobes.xferPol[i] = !(preloadEn && HAS_COMP[i]) || comEvent;
    end
  end
endmodule

// File: rtl/tim_chan_dp.sv
module tim_chan_dp import tim_chan_pkg::*; #(
  parameter int NUM_CH = CH_COUNT,
  parameter logic [CH_COUNT-1:0] HAS_COMP = 4'b0111,
  localparam int REG_W = NUM_CH * FIELD_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobes,
  input  logic [REG_W-1:0]    wrData,
  input  logic [2*NUM_CH-1:0] chMode,
  input  logic [NUM_CH-1:0]   ocRef,
  input  logic [NUM_CH-1:0]   idleLevel,
  input  logic [NUM_CH-1:0]   idleLevelN,
  input  logic [NUM_CH-1:0]   tiIn,
  output logic [REG_W-1:0]    rdData,
  output logic [NUM_CH-1:0]   ocOut,
  output logic [NUM_CH-1:0]   ocOutN,
  output logic [NUM_CH-1:0]   tiPol,
  output logic [NUM_CH-1:0]   capStrobe
);
  logic [NUM_CH-1:0] enQ, polQ, npolQ, actPolQ, prevInQ;
  logic [NUM_CH-1:0] activePol, outMode;
  logic unusedWrBits;

  assign unusedWrBits = ^wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ     <= '0;
      polQ    <= '0;
      npolQ   <= '0;
      actPolQ <= '0;
      prevInQ <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (strobes.ldEn[i])   enQ[i]   <= wrData[i*FIELD_W + EN_OFS];
        if (strobes.ldPol[i])  polQ[i]  <= wrData[i*FIELD_W + POL_OFS];
        if (strobes.ldNPol[i]) npolQ[i] <= wrData[i*FIELD_W + NPOL_OFS];
        if (strobes.xferPol[i]) actPolQ[i] <= polQ[i];
      end
      prevInQ <= tiIn;
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      rdData[i*FIELD_W + EN_OFS]   = enQ[i];
      rdData[i*FIELD_W + POL_OFS]  = polQ[i];
      rdData[i*FIELD_W + NPOL_OFS] = npolQ[i];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [1:0] edgeCode;
    logic rise, fall, hit;

    assign outMode[g]   = (chMode[2*g +: 2] == 2'b00);
    assign activePol[g] = strobes.holdPol[g] ? actPolQ[g] : polQ[g];
    assign edgeCode     = {npolQ[g], activePol[g]};

    assign ocOut[g] = (enQ[g] && outMode[g]) ? (ocRef[g] ^ activePol[g]) : idleLevel[g];

    if (HAS_COMP[g]) begin : gComp
      assign ocOutN[g] = (enQ[g] && outMode[g]) ? (~ocRef[g] ^ npolQ[g]) : idleLevelN[g];
    end else begin : gNoComp
      assign ocOutN[g] = idleLevelN[g];
    end

    assign rise = tiIn[g] && !prevInQ[g];
    assign fall = !tiIn[g] && prevInQ[g];

    always_comb begin
      case (edgeCode)
        2'b01:   hit = fall;
        2'b11:   hit = rise || fall;
        default: hit = rise;       // 00 and reserved 10
      endcase
    end

    assign capStrobe[g] = enQ[g] && !outMode[g] && hit;
    assign tiPol[g]     = tiIn[g] ^ (edgeCode == 2'b01);

    AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
      capStrobe[g] |-> (tiIn[g] != prevInQ[g])); // R5
  end
endmodule

// File: rtl/tim_chan_ctl.sv
module tim_chan_ctl import tim_chan_pkg::*; #(
  parameter int NUM_CH = CH_COUNT,
  parameter logic [CH_COUNT-1:0] HAS_COMP = 4'b0111,
  localparam int REG_W = NUM_CH * FIELD_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [REG_W-1:0]    wrData,
  output logic [REG_W-1:0]    rdData,
  input  logic [1:0]          lockLevel,
  input  logic                preloadEn,
  input  logic                comEvent,
  input  logic [2*NUM_CH-1:0] chMode,
  input  logic [NUM_CH-1:0]   ocRef,
  input  logic [NUM_CH-1:0]   idleLevel,
  input  logic [NUM_CH-1:0]   idleLevelN,
  output logic [NUM_CH-1:0]   ocOut,
  output logic [NUM_CH-1:0]   ocOutN,
  input  logic [NUM_CH-1:0]   tiIn,
  output logic [NUM_CH-1:0]   tiPol,
  output logic [NUM_CH-1:0]   capStrobe
);
  ctlStrobe_t strobes;

  tim_chan_ctrl #(.NUM_CH(NUM_CH), .HAS_COMP(HAS_COMP)) u_ctrl (
    .wrEn(wrEn), .lockLevel(lockLevel), .chMode(chMode),
    .preloadEn(preloadEn), .comEvent(comEvent), .strobes(strobes)
  );

  tim_chan_dp #(.NUM_CH(NUM_CH), .HAS_COMP(HAS_COMP)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .chMode(chMode), .ocRef(ocRef), .idleLevel(idleLevel),
    .idleLevelN(idleLevelN), .tiIn(tiIn), .rdData(rdData),
    .ocOut(ocOut), .ocOutN(ocOutN), .tiPol(tiPol), .capStrobe(capStrobe)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      wrEn |=> rdData[g*FIELD_W + EN_OFS] == $past(wrData[g*FIELD_W + EN_OFS])); // R2
    AST_LOCK_POL: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && lockLevel[1]) |=> $stable(rdData[g*FIELD_W + POL_OFS])); // R9
    AST_NPOL_LOCK: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && lockLevel[1] && chMode[2*g +: 2] == 2'b00) |=> $stable(rdData[g*FIELD_W + NPOL_OFS])); // R10
    if (HAS_COMP[g]) begin : gPre
      AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        (preloadEn && !comEvent) |=> $stable(u_dp.actPolQ[g])); // R11
    end
  end
endmodule

// File: tb/sim_tim_chan_ctl.sv
module sim_tim_chan_ctl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [1:0]  lockLevel = 2'd0;
  logic        preloadEn = 1'b0;
  logic        comEvent = 1'b0;
  logic [7:0]  chMode = 8'h00;
  logic [3:0]  ocRef = 4'b0101;
  logic [3:0]  idleLevel = 4'b0011;
  logic [3:0]  idleLevelN = 4'b1100;
  logic [3:0]  ocOut, ocOutN, tiIn, tiPol, capStrobe;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    int    sel;
    logic [15:0] exp;
    logic [15:0] mask;
    string req;
  } sbItem_t;
  sbItem_t sbQ[$];

  always #10 clk = ~clk;   // 50 MHz

  initial tiIn = 4'b0000;

  tim_chan_ctl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .lockLevel(lockLevel), .preloadEn(preloadEn), .comEvent(comEvent),
    .chMode(chMode), .ocRef(ocRef), .idleLevel(idleLevel),
    .idleLevelN(idleLevelN), .ocOut(ocOut), .ocOutN(ocOutN),
    .tiIn(tiIn), .tiPol(tiPol), .capStrobe(capStrobe)
  );

  function automatic logic [15:0] observe(int sel);
    case (sel)
      0: return rdData;
      1: return {12'h0, ocOut};
      2: return {12'h0, ocOutN};
      3: return {12'h0, capStrobe};
      default: return {12'h0, tiPol};
    endcase
  endfunction

  // driver side: queue an expectation
  task automatic expectVal(int sel, logic [15:0] exp, logic [15:0] mask, string req);
    sbItem_t it;
    it.sel = sel; it.exp = exp; it.mask = mask; it.req = req;
    sbQ.push_back(it);
    #1;
  endtask

  // monitor side: pop and compare
  always begin
    sbItem_t it;
    logic [15:0] act;
    wait (sbQ.size() != 0);
    it = sbQ.pop_front();
    act = observe(it.sel) & it.mask;
    checks++;
    if (act !== (it.exp & it.mask)) begin
      fails++;
      $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp & it.mask);
    end
  end

  task automatic writeReg(logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
    #2;
  endtask

  task automatic comPulse();
    @(negedge clk); comEvent = 1'b1;
    @(negedge clk); comEvent = 1'b0;
    #2;
  endtask

  task automatic setIn(logic [3:0] v);
    @(negedge clk); tiIn = v;
    #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    // R1 reset state, R3/R4 idle levels while disabled
    expectVal(0, 16'h0000, 16'hFFFF, "R1");
    expectVal(1, 16'h0003, 16'h000F, "R3");
    expectVal(2, 16'h000C, 16'h000F, "R4");

    writeReg(16'hFFFF);
    expectVal(0, 16'hBBBB, 16'hFFFF, "R1");
    expectVal(1, 16'h000A, 16'h000F, "R3");   // active low: ~ocRef
    expectVal(2, 16'h000D, 16'h000F, "R4");   // ch1-3 = ocRef, ch4 idle

    writeReg(16'h1111);
    expectVal(1, 16'h0005, 16'h000F, "R3");
    expectVal(2, 16'h000A, 16'h000F, "R4");

    // lock tests
    writeReg(16'hBBBB);
    lockLevel = 2'd2;
    writeReg(16'h0000);
    expectVal(0, 16'h0000, 16'h1111, "R2");
    expectVal(0, 16'h2222, 16'h2222, "R9");
    expectVal(0, 16'h8888, 16'h8888, "R10");
    chMode = 8'b0000_0001;               // ch1 input
    lockLevel = 2'd3;
    writeReg(16'h0000);
    expectVal(0, 16'hAAA2, 16'hFFFF, "R10");
    lockLevel = 2'd1;
    writeReg(16'h0000);
    expectVal(0, 16'h0000, 16'hFFFF, "R9");
    chMode = 8'h00;
    lockLevel = 2'd0;

    // preload
    writeReg(16'h1111);
    preloadEn = 1'b1;
    writeReg(16'h3333);
    expectVal(0, 16'h3333, 16'hFFFF, "R11");
    expectVal(1, 16'h0005, 16'h0007, "R11");
    expectVal(1, 16'h0008, 16'h0008, "R12");
    comPulse();
    expectVal(1, 16'h000A, 16'h000F, "R11");
    preloadEn = 1'b0;

    // input mode edge selection
    chMode = 8'b0101_0101;
    writeReg(16'h9B31);   // ch1 00, ch2 01, ch3 11, ch4 10
    setIn(4'b1111);
    expectVal(3, 16'h0005, 16'h0007, "R5");
    expectVal(3, 16'h0008, 16'h0008, "R6");
    expectVal(4, 16'h000D, 16'h000F, "R8");
    @(negedge clk); #2;
    expectVal(3, 16'h0000, 16'h000F, "R5");
    setIn(4'b0000);
    expectVal(3, 16'h0006, 16'h000F, "R5");
    expectVal(4, 16'h0002, 16'h000F, "R8");
    @(negedge clk); #2;
    expectVal(3, 16'h0000, 16'h000F, "R6");

    // gating: ch1 disabled, ch3 output mode
    writeReg(16'h9B30);
    chMode = 8'b0100_0101;
    setIn(4'b1111);
    expectVal(3, 16'h0008, 16'h000F, "R7");
    setIn(4'b0000);

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule